// File: doc/BRIEF.md
# ISA Interrupt Collector Register Block

This block gathers up to eight interrupt request lines from a legacy ISA expansion bus. Each supported line is synchronized to the host clock. A rising edge on the line sets one bit in a dense 8-bit pending register. The OR of all pending bits is registered and driven on a single summary line toward the host processor. The host treats that line as rising-edge triggered. It reads the pending register, services the lowest set bit, and acknowledges sources by writing a mask of ones. It keeps re-reading until nothing is left pending.

Besides the interrupt register, the block decodes three other registers from a sparse address window:
- a read-only version/issue byte, fixed at build time;
- a control register whose bit 0 drives the CompactFlash card reset;
- a placeholder slot for an external watchdog.

All four are reached over a simple strobe-based host bus with 16-bit data. Read data comes back registered, one cycle after the read strobe.

Top module: `isa_irq_collector`

## Requirements
- R1: The ISA request input is 13 bits wide, indexed by ISA IRQ number. Lines 3, 4, 5, 6, 7 map to pending bits 0 to 4, and lines 10, 11, 12 map to pending bits 5 to 7. A bit is set by a rising edge of its line after a two-stage synchronizer, three clock edges after the line rises. A line that stays high does not set its bit again after an acknowledge.
- R2: ISA lines 0, 1, 2, 8 and 9 have no pending bit, and activity on them changes neither the pending register nor the summary output.
- R3: A read with register select 1 returns the pending bits in data bits [7:0], with bits [15:8] zero. Read data is valid on the clock after the read strobe is sampled.
- R4: A write with register select 1 clears exactly the pending bits whose data bit is 1. Bits written as 0 keep their value.
- R5: When a rising edge sets a bit in the same cycle that a write acknowledges it, the bit ends up set.
- R6: `host_irq_o` is a registered OR of the pending bits. It rises one clock after the first bit is set and falls one clock after the last bit is cleared.
- R7: The register select is address bits [24:23]: 0 version, 1 interrupt, 2 control, 3 watchdog. All lower address bits are ignored, so any offset inside a register's 8 MB slice reaches that register.
- R8: A version read returns parameter `VERSION_VAL` (version number in bits [7:4], issue in bits [3:0]) with zero upper bits. Writes to it have no effect.
- R9: Control bit 0 is read/write and drives `cf_reset_o`. Control bits [15:1] read as zero.
- R10: The watchdog register reads as zero, and writes to it change no output or register.
- R11: A synchronous active-high reset clears the pending bits, the control register and `host_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| isa_req_i | input | 13 | ISA request lines, index = IRQ number |
| bus_addr_i | input | 25 | Byte offset inside the 32 MB window |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| host_irq_o | output | 1 | Summary interrupt to the host |
| cf_reset_o | output | 1 | CompactFlash reset, from control bit 0 |

## Verification
The checker assumes the following about the inputs:
- read and write strobes are never asserted together;
- request lines are quiet or held steady long enough for the synchronizer;
- the reset is asserted at time zero.

The bench drives every input half a cycle away from the rising edge and issues one access at a time. It holds each request line for four cycles, so every edge crosses the synchronizer cleanly. For the set-versus-acknowledge collision, the acknowledge write is placed in the exact cycle that the detected edge reaches the pending register.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;

   localparam int unsigned NUM_SRC   = 8;
   localparam int unsigned ISA_LINES = 13;

   typedef enum logic [1:0] {
      SEL_VERSION = 2'd0,
      SEL_IRQ     = 2'd1,
      SEL_CTRL    = 2'd2,
      SEL_WDOG    = 2'd3
   } reg_sel_e;

   // Dense pending bit -> ISA IRQ number (IRQs 3..7 then 10..12).
   function automatic int unsigned isa_line_of(int unsigned bitpos);
      return (bitpos < 5) ? bitpos + 3 : bitpos + 5;
   endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_i,
   output logic rise_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   initial begin
      if (STAGES < 2) $error("irq_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], line_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] ack_i,
   output logic [WIDTH-1:0] pend_o,
   output logic             any_o
);
   logic [WIDTH-1:0] pend_q;
   logic             any_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
         any_q  <= 1'b0;
      end else begin
         // a new edge outranks an acknowledge of the same bit
         pend_q <= (pend_q & ~ack_i) | set_i;
         any_q  <= |pend_q;
      end
   end

   assign pend_o = pend_q;
   assign any_o  = any_q;
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
   import isa_irq_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 25,
   parameter int unsigned SRC_W       = 8,
   parameter int unsigned CTRL_W      = 1,
   parameter logic [7:0]  VERSION_VAL = 8'h11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [SRC_W-1:0]  pend_i,
   output logic [SRC_W-1:0]  ack_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned LOW_W = ADDR_W - 2;

   reg_sel_e          sel;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rd_mux;
   logic              unused_bits;

   assign sel = reg_sel_e'(addr_i[ADDR_W-1 -: 2]);
   assign unused_bits = ^{addr_i[LOW_W-1:0], wdata_i[DATA_W-1:SRC_W]};

   assign ack_o = (wr_i && sel == SEL_IRQ) ? wdata_i[SRC_W-1:0] : '0;

   always_comb begin
      unique case (sel)
         SEL_VERSION: rd_mux = DATA_W'(VERSION_VAL);
         SEL_IRQ:     rd_mux = DATA_W'(pend_i);
         SEL_CTRL:    rd_mux = DATA_W'(ctrl_q);
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (wr_i && sel == SEL_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
         if (rd_i) rdata_q <= rd_mux;
      end
   end

   assign ctrl_o  = ctrl_q;
   assign rdata_o = rdata_q;
endmodule

// File: rtl/isa_irq_collector.sv
module isa_irq_collector
   import isa_irq_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 25,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CTRL_W      = 1,
   parameter logic [7:0]  VERSION_VAL = 8'h11
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ISA_LINES-1:0] isa_req_i,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   input  logic                 bus_wr_i,
   input  logic                 bus_rd_i,
   input  logic [DATA_W-1:0]    bus_wdata_i,
   output logic [DATA_W-1:0]    bus_rdata_o,
   output logic                 host_irq_o,
   output logic                 cf_reset_o
);
   initial begin
      if (DATA_W < NUM_SRC) $error("isa_irq_collector: DATA_W too narrow");
      if (CTRL_W < 1 || CTRL_W > DATA_W) $error("isa_irq_collector: bad CTRL_W");
      if (ADDR_W < 3) $error("isa_irq_collector: ADDR_W too small");
   end

   logic [NUM_SRC-1:0] rise_w;
   logic [NUM_SRC-1:0] ack_w;
   logic [NUM_SRC-1:0] pend_q;
   logic [CTRL_W-1:0]  ctrl_w;
   logic               unused_lines;

   assign unused_lines = ^{isa_req_i[9:8], isa_req_i[2:0]};

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst    (rst),
         .line_i (isa_req_i[isa_line_of(k)]),
         .rise_o (rise_w[k])
      );
   end

   irq_pending_bank #(.WIDTH(NUM_SRC)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_i  (rise_w),
      .ack_i  (ack_w),
      .pend_o (pend_q),
      .any_o  (host_irq_o)
   );

   irq_reg_file #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_W(NUM_SRC),
      .CTRL_W(CTRL_W), .VERSION_VAL(VERSION_VAL)
   ) u_regs (
      .clk     (clk),
      .rst     (rst),
      .addr_i  (bus_addr_i),
      .wr_i    (bus_wr_i),
      .rd_i    (bus_rd_i),
      .wdata_i (bus_wdata_i),
      .pend_i  (pend_q),
      .ack_o   (ack_w),
      .ctrl_o  (ctrl_w),
      .rdata_o (bus_rdata_o)
   );

   assign cf_reset_o = ctrl_w[0];
endmodule

// File: rtl/isa_irq_collector_chk.sv
module isa_irq_collector_chk #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 25,
   parameter int unsigned SRC_W       = 8,
   parameter logic [7:0]  VERSION_VAL = 8'h11
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_wr_i,
   input logic              bus_rd_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              host_irq_o,
   input logic              cf_reset_o,
   input logic [SRC_W-1:0]  pend,
   input logic [SRC_W-1:0]  rise,
   input logic [SRC_W-1:0]  ack
);
   logic [1:0] sel;
   assign sel = bus_addr_i[ADDR_W-1 -: 2];

   for (genvar k = 0; k < SRC_W; k++) begin : g_bit
      // R4: acknowledged bit with no fresh edge is cleared next cycle
      a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
         (ack[k] && !rise[k]) |=> !pend[k]);
      // R5: detected edge always lands, even against an acknowledge
      a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
         rise[k] |=> pend[k]);
      // R1: a pending bit only appears after a detected edge
      a_r1_set_by_edge: assert property (@(posedge clk) disable iff (rst)
         $rose(pend[k]) |-> $past(rise[k]));
   end

   // R6: summary output follows the pending OR one cycle later
   a_r6_summary: assert property (@(posedge clk) disable iff (rst)
      host_irq_o == (|$past(pend)));

   // R8: version read returns the build value
   a_r8_version: assert property (@(posedge clk) disable iff (rst)
      (bus_rd_i && sel == 2'd0) |=> bus_rdata_o == DATA_W'(VERSION_VAL));

   // R9: control write drives the card reset output
   a_r9_ctrl_out: assert property (@(posedge clk) disable iff (rst)
      (bus_wr_i && sel == 2'd2) |=> cf_reset_o == $past(bus_wdata_i[0]));

   // R10: watchdog reads as zero
   a_r10_wdog_zero: assert property (@(posedge clk) disable iff (rst)
      (bus_rd_i && sel == 2'd3) |=> bus_rdata_o == '0);

   // R11: reset clears pending, control and summary
   a_r11_reset: assert property (@(posedge clk)
      rst |=> (pend == '0 && !cf_reset_o && !host_irq_o));
endmodule

bind isa_irq_collector isa_irq_collector_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_W(isa_irq_pkg::NUM_SRC),
   .VERSION_VAL(VERSION_VAL)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .bus_addr_i  (bus_addr_i),
   .bus_wr_i    (bus_wr_i),
   .bus_rd_i    (bus_rd_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .host_irq_o  (host_irq_o),
   .cf_reset_o  (cf_reset_o),
   .pend        (pend_q),
   .rise        (rise_w),
   .ack         (ack_w)
);

// File: tb/tb_isa_irq_collector.sv
module tb_isa_irq_collector;
   localparam logic [7:0] VER = 8'h3A;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [12:0] isa = '0;
   logic [24:0] addr = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        host_irq;
   logic        cf_reset;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   isa_irq_collector #(.VERSION_VAL(VER)) dut (
      .clk(clk), .rst(rst), .isa_req_i(isa),
      .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .host_irq_o(host_irq), .cf_reset_o(cf_reset)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   function automatic logic [24:0] mk_addr(logic [1:0] sel, logic [22:0] low);
      return {sel, low};
   endfunction

   task automatic bus_write(logic [1:0] sel, logic [15:0] d, logic [22:0] low = '0);
      @(negedge clk);
      addr = mk_addr(sel, low); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] sel, output logic [15:0] d, input logic [22:0] low = '0);
      @(negedge clk);
      addr = mk_addr(sel, low); rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic pulse_line(int line);
      @(negedge clk); isa[line] = 1'b1;
      repeat (4) @(negedge clk);
      isa[line] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      check("R11 reset host_irq", 16'(host_irq), 16'h0);
      check("R11 reset cf_reset", 16'(cf_reset), 16'h0);
      bus_read(2'd1, d);
      check("R11 reset pending", d, 16'h0000);
   endtask

   task automatic t_mapping();
      logic [15:0] d;
      for (int k = 0; k < 8; k++) begin
         int line = (k < 5) ? k + 3 : k + 5;
         pulse_line(line);
         bus_read(2'd1, d);
         check($sformatf("R1 R3 line %0d", line), d, 16'(1 << k));
         bus_write(2'd1, 16'(1 << k));
         bus_read(2'd1, d);
         check($sformatf("R4 ack line %0d", line), d, 16'h0000);
      end
   endtask

   task automatic t_unsupported();
      logic [15:0] d;
      pulse_line(0); pulse_line(1); pulse_line(2); pulse_line(8); pulse_line(9);
      bus_read(2'd1, d);
      check("R2 unsupported pending", d, 16'h0000);
      check("R2 unsupported host_irq", 16'(host_irq), 16'h0);
   endtask

   task automatic t_w1c_partial();
      logic [15:0] d;
      pulse_line(4); pulse_line(6); pulse_line(11);   // bits 1,3,6
      bus_read(2'd1, d);
      check("R1 three sources", d, 16'h004A);
      bus_write(2'd1, 16'hFF08);                      // clears bit 3 only
      bus_read(2'd1, d);
      check("R4 partial clear", d, 16'h0042);
      bus_write(2'd1, 16'h0042);
      bus_read(2'd1, d);
      check("R4 full clear", d, 16'h0000);
   endtask

   task automatic t_held_line();
      logic [15:0] d;
      @(negedge clk); isa[12] = 1'b1;
      repeat (4) @(negedge clk);
      bus_write(2'd1, 16'h0080);
      repeat (4) @(negedge clk);
      bus_read(2'd1, d);
      check("R1 held level no re-set", d, 16'h0000);
      isa[12] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_collision();
      logic [15:0] d;
      @(negedge clk); isa[5] = 1'b1;                  // bit 2
      @(negedge clk);
      @(negedge clk);
      addr = mk_addr(2'd1, '0); wdata = 16'h0004; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      isa[5] = 1'b0;
      bus_read(2'd1, d);
      check("R5 set beats ack", d, 16'h0004);
      bus_write(2'd1, 16'h0004);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_summary();
      @(negedge clk); isa[3] = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      check("R6 summary not yet", 16'(host_irq), 16'h0);
      @(negedge clk);
      check("R6 summary rises", 16'(host_irq), 16'h1);
      isa[3] = 1'b0;
      bus_write(2'd1, 16'h0001);
      check("R6 summary lags clear", 16'(host_irq), 16'h1);
      @(negedge clk);
      check("R6 summary falls", 16'(host_irq), 16'h0);
   endtask

   task automatic t_decode();
      logic [15:0] d;
      pulse_line(7);                                  // bit 4
      bus_read(2'd1, d, 23'h7FFFFF);
      check("R7 alias high offset", d, 16'h0010);
      bus_write(2'd1, 16'h0010, 23'h001234);
      bus_read(2'd1, d, 23'h000002);
      check("R7 alias ack", d, 16'h0000);
   endtask

   task automatic t_version();
      logic [15:0] d;
      bus_read(2'd0, d);
      check("R8 version", d, 16'(VER));
      bus_write(2'd0, 16'hFFFF);
      bus_read(2'd0, d, 23'h0ABCDE);
      check("R8 version write ignored", d, 16'(VER));
   endtask

   task automatic t_ctrl();
      logic [15:0] d;
      bus_write(2'd2, 16'hFFFF);
      check("R9 cf_reset set", 16'(cf_reset), 16'h1);
      bus_read(2'd2, d);
      check("R9 ctrl readback", d, 16'h0001);
      bus_write(2'd2, 16'hFFFE);
      check("R9 cf_reset cleared", 16'(cf_reset), 16'h0);
   endtask

   task automatic t_wdog();
      logic [15:0] d;
      bus_write(2'd2, 16'h0001);
      bus_write(2'd3, 16'hFFFF);
      bus_read(2'd3, d);
      check("R10 wdog reads zero", d, 16'h0000);
      check("R10 wdog leaves cf_reset", 16'(cf_reset), 16'h1);
      bus_read(2'd1, d);
      check("R10 wdog leaves pending", d, 16'h0000);
   endtask

   task automatic t_reset_mid();
      logic [15:0] d;
      pulse_line(10);
      repeat (2) @(negedge clk);
      check("R11 pre-reset host_irq", 16'(host_irq), 16'h1);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk); rst = 1'b0;
      check("R11 host_irq cleared", 16'(host_irq), 16'h0);
      check("R11 ctrl cleared", 16'(cf_reset), 16'h0);
      bus_read(2'd1, d);
      check("R11 pending cleared", d, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_mapping();
      t_unsupported();
      t_w1c_partial();
      t_held_line();
      t_collision();
      t_summary();
      t_decode();
      t_version();
      t_ctrl();
      t_wdog();
      t_reset_mid();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule